// File: doc/BRIEF.md
# Dynamic Branch Predictor with Target Cache

This block sits beside the fetch stage and answers one question each cycle: where should fetch go next? It has two tables. The first is a direct-mapped table of 2-bit saturating counters, selected by low word-address bits of the fetch PC, and it gives the predicted direction. The second is a small direct-mapped, tagged cache of branch targets. When the counter predicts taken and the target cache holds a matching entry, the predicted next PC is the cached target, so fetch is redirected with no bubble. Otherwise the predicted next PC is the sequential address PC+4. If the direction is taken but no target is cached, the pipeline still spends one cycle computing the target.

When a branch resolves, the pipeline reports its PC, its real direction and its real target on a single-cycle update port. The selected counter moves one step toward the outcome and saturates at both ends. Because of this two-step hysteresis, the predicted direction flips only after two wrong outcomes in a row. A loop branch that is strongly taken therefore mispredicts once at loop exit and not a second time on re-entry. A taken outcome also writes the target cache entry. Lookups read the tables combinationally. An update in the same cycle becomes visible only after the clock edge. Flush generation is left to the pipeline.

Top module: `brpred_unit`

## Requirements
- R1: After reset every counter holds weakly-not-taken (01) and every target cache entry is invalid, so any fetch PC gives pred_taken=0 and pred_next_pc=PC+4.
- R2: The counter for a PC is selected by PC bits [HIST_IDX_W+1:2] (bits [7:2] by default). PCs that differ only outside those bits share one counter; PCs that differ inside them use separate counters.
- R3: Counter encoding is 00 strong-not-taken, 01 weak-not-taken, 10 weak-taken, 11 strong-taken. A taken update adds one and saturates at 11. A not-taken update subtracts one and saturates at 00.
- R4: pred_taken is the counter's upper bit. From 11, one not-taken update leaves the prediction taken, and a second one makes it not-taken.
- R5: A taken update writes the target cache entry selected by PC bits [TGT_IDX_W+1:2] (bits [5:2] by default). The write sets valid, stores PC bits [31:TGT_IDX_W+2] as the tag, and stores the given target, replacing any earlier target.
- R6: pred_next_pc equals the cached target when pred_taken=1 and the selected entry is valid with a matching tag. Otherwise it is fetch_pc+4, computed modulo 2^32.
- R7: A tag mismatch gives PC+4 even when the shared counter predicts taken. A taken update from a different PC that maps to the same entry evicts the earlier target.
- R8: A not-taken update leaves the target cache unchanged.
- R9: When an update and a lookup hit the same entry in one cycle, the lookup returns the old prediction. The new prediction appears from the following cycle.
- R10: With upd_valid low, no table changes, whatever values the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | PC being fetched this cycle |
| pred_taken | output | 1 | Predicted direction for fetch_pc |
| pred_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | 32 | Actual target of the resolved branch |

## Verification
A corrupted counter shows on pred_taken for that PC's index in the cycle after the bad update, or one update later when the fault is off by a single step. That is why the stimulus walks one counter through every state and both saturation points. A wrong target cache valid bit, tag or payload shows only on pred_next_pc, and only while the shared counter predicts taken. The bench therefore trains the direction to taken before probing hits, aliases and evictions. Same-cycle visibility is sampled both before and after the update edge.

// File: rtl/brpred_pkg.sv
package brpred_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_e;

  localparam ctr_e CTR_RESET = CTR_WEAK_NT;

  // One saturating step toward the observed outcome.
  function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'd1);
    end else begin
      if (cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'd1);
    end
    return nxt;
  endfunction

  function automatic logic ctr_taken(input ctr_e c);
    return c[1];
  endfunction

endpackage

// File: rtl/brpred_hist.sv
module brpred_hist
  import brpred_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_taken,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic            wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
    return pc[IDX_W+1:2];
  endfunction

  logic [DEPTH-1:0][1:0] ctr_q;
  logic [IDX_W-1:0]      rd_idx;
  logic [IDX_W-1:0]      wr_idx;
  ctr_e                  rd_ctr;
  ctr_e                  wr_ctr_old;
  ctr_e                  wr_ctr_new;

  assign rd_idx     = idx_of(rd_pc);
  assign wr_idx     = idx_of(wr_pc);
  assign rd_ctr     = ctr_e'(ctr_q[rd_idx]);
  assign wr_ctr_old = ctr_e'(ctr_q[wr_idx]);
  assign wr_ctr_new = ctr_step(wr_ctr_old, wr_taken);
  assign rd_taken   = ctr_taken(rd_ctr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_RESET;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_ctr_new;
    end
  end

  AST_CTR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_ctr_old != CTR_STRONG_T)
      |=> ctr_q[$past(wr_idx)] == 2'($past(wr_ctr_old) + 2'd1)); // R3
  AST_CTR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_ctr_old != CTR_STRONG_NT)
      |=> ctr_q[$past(wr_idx)] == 2'($past(wr_ctr_old) - 2'd1)); // R3
  AST_CTR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_taken && wr_ctr_old == CTR_STRONG_T) ||
               (!wr_taken && wr_ctr_old == CTR_STRONG_NT)))
      |=> $stable(ctr_q)); // R3
  AST_HIST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctr_q)); // R10

endmodule

// File: rtl/brpred_tgt.sv
module brpred_tgt #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output logic [PC_W-1:0] rd_tgt,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_tgt
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - 2;

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
    return pc[IDX_W+1:2];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    return pc[PC_W-1:IDX_W+2];
  endfunction

  logic [DEPTH-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [PC_W-1:0]   tgt_q [DEPTH];
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic              tag_match;

  assign rd_idx    = idx_of(rd_pc);
  assign wr_idx    = idx_of(wr_pc);
  assign wr_tag    = tag_of(wr_pc);
  assign tag_match = tag_q[rd_idx] == tag_of(rd_pc);
  assign rd_hit    = vld_q[rd_idx] && tag_match;
  assign rd_tgt    = tgt_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt;
    end
  end

  AST_TGT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
               && tgt_q[$past(wr_idx)] == $past(wr_tgt))); // R5
  AST_TGT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld_q)); // R8

endmodule

// File: rtl/brpred_sel.sv
module brpred_sel #(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            dir_taken,
  input  logic            tgt_hit,
  input  logic [PC_W-1:0] tgt_pc,
  output logic            redirect,
  output logic [PC_W-1:0] next_pc
);

  function automatic logic [PC_W-1:0] seq_pc(input logic [PC_W-1:0] pc);
    return pc + PC_W'(4);
  endfunction

  assign redirect = dir_taken && tgt_hit;
  assign next_pc  = redirect ? tgt_pc : seq_pc(fetch_pc);

endmodule

// File: rtl/brpred_unit.sv
module brpred_unit #(
  parameter int PC_W       = 32,
  parameter int HIST_IDX_W = 6,
  parameter int TGT_IDX_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);

  logic            dir_taken;
  logic            tgt_hit;
  logic [PC_W-1:0] tgt_pc;
  logic            tgt_wr_en;
  logic            redirect;

  assign tgt_wr_en = upd_valid && upd_taken;

  brpred_hist #(.PC_W(PC_W), .IDX_W(HIST_IDX_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_pc    (fetch_pc),
    .rd_taken (dir_taken),
    .wr_en    (upd_valid),
    .wr_pc    (upd_pc),
    .wr_taken (upd_taken)
  );

  brpred_tgt #(.PC_W(PC_W), .IDX_W(TGT_IDX_W)) u_tgt (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_pc  (fetch_pc),
    .rd_hit (tgt_hit),
    .rd_tgt (tgt_pc),
    .wr_en  (tgt_wr_en),
    .wr_pc  (upd_pc),
    .wr_tgt (upd_target)
  );

  brpred_sel #(.PC_W(PC_W)) u_sel (
    .fetch_pc  (fetch_pc),
    .dir_taken (dir_taken),
    .tgt_hit   (tgt_hit),
    .tgt_pc    (tgt_pc),
    .redirect  (redirect),
    .next_pc   (pred_next_pc)
  );

  assign pred_taken = dir_taken;

  AST_SEQ_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_hit |-> pred_next_pc == fetch_pc + PC_W'(4)); // R7
  AST_SEQ_ON_NT: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_taken |-> pred_next_pc == fetch_pc + PC_W'(4)); // R6
  AST_REDIRECT_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && tgt_pc != fetch_pc + PC_W'(4)) |-> pred_next_pc != fetch_pc + PC_W'(4)); // R6

endmodule

// File: tb/brpred_unit_tb.sv
`timescale 1ns/100ps
module brpred_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_taken;
  logic [31:0] pred_next_pc;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  brpred_unit u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_pc     (fetch_pc),
    .pred_taken   (pred_taken),
    .pred_next_pc (pred_next_pc),
    .upd_valid    (upd_valid),
    .upd_pc       (upd_pc),
    .upd_taken    (upd_taken),
    .upd_target   (upd_target)
  );

  localparam logic [31:0] PA = 32'h0000_1010; // hist idx 4, tgt idx 4
  localparam logic [31:0] PB = 32'h0000_1110; // same indices, other tag
  localparam logic [31:0] PC = 32'h0000_1014; // hist idx 5

  typedef struct packed {
    logic        uv;
    logic [31:0] upc;
    logic        ut;
    logic [31:0] utg;
    logic [31:0] fpc;
    logic        et;
    logic [31:0] enx;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam logic [$bits(vec_t)-1:0] VEC [NV] = '{
    {1'b0, 32'h0,  1'b0, 32'h0,         PA, 1'b0, 32'h0000_1014, 4'd1},  // R1 idle
    {1'b1, PA,     1'b1, 32'h0000_2000, PA, 1'b1, 32'h0000_2000, 4'd5},  // R5 01->10, fill
    {1'b1, PA,     1'b1, 32'h0000_2000, PA, 1'b1, 32'h0000_2000, 4'd3},  // R3 10->11
    {1'b1, PA,     1'b1, 32'h0000_2000, PA, 1'b1, 32'h0000_2000, 4'd3},  // R3 sat 11
    {1'b1, PA,     1'b0, 32'h0,         PA, 1'b1, 32'h0000_2000, 4'd4},  // R4 11->10 still taken
    {1'b1, PA,     1'b0, 32'h0,         PA, 1'b0, 32'h0000_1014, 4'd4},  // R4 10->01 flips
    {1'b1, PA,     1'b0, 32'h0,         PA, 1'b0, 32'h0000_1014, 4'd3},  // R3 01->00
    {1'b1, PA,     1'b0, 32'h0,         PA, 1'b0, 32'h0000_1014, 4'd3},  // R3 sat 00
    {1'b1, PA,     1'b1, 32'h0000_2000, PA, 1'b0, 32'h0000_1014, 4'd3},  // R3 00->01
    {1'b1, PA,     1'b1, 32'h0000_3000, PA, 1'b1, 32'h0000_3000, 4'd5},  // R5 01->10, retarget
    {1'b0, 32'h0,  1'b0, 32'h0,         PB, 1'b1, 32'h0000_1114, 4'd7},  // R7 tag miss, shared ctr
    {1'b0, PA,     1'b0, 32'h0000_dead, PA, 1'b1, 32'h0000_3000, 4'd10}, // R10 gated update
    {1'b0, 32'h0,  1'b0, 32'h0,         PC, 1'b0, 32'h0000_1018, 4'd2},  // R2 neighbour idx
    {1'b0, 32'h0,  1'b0, 32'h0, 32'hffff_fffc, 1'b0, 32'h0000_0000, 4'd6}, // R6 wrap
    {1'b1, PB,     1'b1, 32'h0000_4000, PA, 1'b1, 32'h0000_1014, 4'd7},  // R7 eviction, ctr 11
    {1'b0, 32'h0,  1'b0, 32'h0,         PB, 1'b1, 32'h0000_4000, 4'd5},  // R5 new owner hits
    {1'b1, PB,     1'b0, 32'h0,         PB, 1'b1, 32'h0000_4000, 4'd8}   // R8 nt keeps target
  };

  task automatic check(input logic got_t, input logic [31:0] got_n,
                       input logic exp_t, input logic [31:0] exp_n,
                       input int req, input string what);
    total++;
    if (got_t !== exp_t || got_n !== exp_n) begin
      bad++;
      $display("FAIL R%0d %s: taken=%0b next=%h expected taken=%0b next=%h",
               req, what, got_t, got_n, exp_t, exp_n);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state over several PCs
    fetch_pc = PA; #1 check(pred_taken, pred_next_pc, 1'b0, 32'h0000_1014, 1, "reset A");
    fetch_pc = 32'h8000_0040; #1 check(pred_taken, pred_next_pc, 1'b0, 32'h8000_0044, 1, "reset hi");

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      @(negedge clk);
      upd_valid = v.uv; upd_pc = v.upc; upd_taken = v.ut; upd_target = v.utg;
      fetch_pc = v.fpc;
      @(negedge clk);
      check(pred_taken, pred_next_pc, v.et, v.enx, int'(v.req), $sformatf("vector %0d", i));
      upd_valid = 1'b0;
    end

    // R9 same-cycle update and lookup: old value first, new after the edge
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = PC; upd_taken = 1'b1; upd_target = 32'h0000_5000;
    fetch_pc = PC;
    #1 check(pred_taken, pred_next_pc, 1'b0, 32'h0000_1018, 9, "before edge");
    @(posedge clk);
    #1 check(pred_taken, pred_next_pc, 1'b1, 32'h0000_5000, 9, "after edge");
    upd_valid = 1'b0;

    // R1 reset in mid-run clears trained state
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    fetch_pc = PB; #1 check(pred_taken, pred_next_pc, 1'b0, 32'h0000_1114, 1, "rerst B");
    fetch_pc = PC; #1 check(pred_taken, pred_next_pc, 1'b0, 32'h0000_1018, 1, "rerst C");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule